// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port reached through a plain 32-bit register bus. Each access is a single-cycle strobe and has no handshake. Software holds an output value and a per-pin direction. It reads the synchronized level of every pad. Each pin can raise an interrupt when its pad is low, when it is high, on a rising edge, on a falling edge, or on both edges.

Detected events collect in a sticky status register, which software clears by writing ones to it. A mask register gates the status bits onto two interrupt lines. One line serves pins 0 to 15 and the other serves pins 16 to 31. This lets an interrupt controller route each half of the port on its own.

Pads are sampled through a two-stage synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0. Reads at byte offsets 0x20 and above return 0. The word map is: 0x00 data out, 0x04 direction, 0x08 pad level (read-only), 0x0C trigger config for pins 0–15, 0x10 trigger config for pins 16–31, 0x14 mask, 0x18 status, 0x1C dual-edge select.
- R2: The data-out register reads back the value last written to it, whatever the pad level. `pad_out` always carries that value. `pad_oe` bit n is 1 exactly when direction bit n is 1, and a 1 makes pin n an output.
- R3: The pad-level register shows `pad_in` two clock edges after it is applied, through a two-flop synchronizer.
- R4: Pin n has a 2-bit trigger code at bits 2·(n mod 16)+1 : 2·(n mod 16). That field sits in the low config word for pins 0–15 and in the high config word for pins 16–31. The codes are 0 = low level, 1 = high level, 2 = rising edge and 3 = falling edge.
- R5: When dual-edge select bit n is 1, pin n records an event on every change of its synchronized level, and its 2-bit trigger code has no effect.
- R6: A status bit is set by an event and then holds. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: A level-triggered status bit is set again on every cycle that its level persists. A clear in the same cycle as the level does not remove it.
- R8: `irq_lo` is the OR of bits 0–15 of (status AND mask). `irq_hi` is the OR of bits 16–31 of that product. An edge event reaches its status bit and interrupt line three clock edges after the pad changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32 | Pad levels (asynchronous) |
| pad_out | output | 32 | Output value for the pads |
| pad_oe | output | 32 | Output enable per pad |
| irq_lo | output | 1 | Interrupt request for pins 0–15 |
| irq_hi | output | 1 | Interrupt request for pins 16–31 |

## Verification
The bench aims at the clear-versus-level race. A design that lets the clear win would show a level-triggered bit dropping for a cycle while its level is still present. It checks that the dual-edge select overrides the 2-bit code. A design that ignored it would miss one edge direction or fire on a steady level.

It places pins on both sides of the 15/16 boundary. A mistake in field placement or in the split between the two interrupt lines would then light the wrong line or the wrong bit. It also counts the synchronizer latency exactly. An extra or missing flop would move the pad-level and status updates by one cycle and fail the directed timing checks.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq_lo,
  output logic            irq_hi
);
  localparam int HALF = NPIN / 2;

  logic [NPIN-1:0]   dout_q, dir_q, mask_q, sts_q, dual_q;
  logic [NPIN-1:0]   sync1_q, sync2_q, prev_q, evt;
  logic [2*NPIN-1:0] trig_q;
  logic [AW-3:0]     word;

  assign word = bus_addr[AW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      if (dual_q[i]) evt[i] = sync2_q[i] ^ prev_q[i];
      else begin
        case (trig_q[2*i +: 2])
          2'd0:    evt[i] = ~sync2_q[i];
          2'd1:    evt[i] = sync2_q[i];
          2'd2:    evt[i] = sync2_q[i] & ~prev_q[i];
          default: evt[i] = ~sync2_q[i] & prev_q[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      trig_q <= '0;
      mask_q <= '0;
      sts_q  <= '0;
      dual_q <= '0;
    end else begin
      if (bus_wr) begin
        case (word)
          'd0: dout_q <= bus_wdata;
          'd1: dir_q  <= bus_wdata;
          'd3: trig_q[HALF*2-1:0]      <= bus_wdata;
          'd4: trig_q[NPIN*2-1:HALF*2] <= bus_wdata;
          'd5: mask_q <= bus_wdata;
          'd7: dual_q <= bus_wdata;
          default: ;
        endcase
      end
      if (bus_wr && word == 'd6) sts_q <= (sts_q & ~bus_wdata) | evt;
      else                       sts_q <= sts_q | evt;
    end
  end

  always_comb begin
    case (word)
      'd0:     bus_rdata = dout_q;
      'd1:     bus_rdata = dir_q;
      'd2:     bus_rdata = sync2_q;
      'd3:     bus_rdata = trig_q[HALF*2-1:0];
      'd4:     bus_rdata = trig_q[NPIN*2-1:HALF*2];
      'd5:     bus_rdata = mask_q;
      'd6:     bus_rdata = sts_q;
      'd7:     bus_rdata = dual_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;
  assign irq_lo  = |(sts_q[HALF-1:0] & mask_q[HALF-1:0]);
  assign irq_hi  = |(sts_q[NPIN-1:HALF] & mask_q[NPIN-1:HALF]);

  // R6
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && word == 'd6) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  // R6
  sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == 'd6) |=> ((sts_q & $past(bus_wdata) & ~$past(evt)) == '0));

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (!irq_lo && !irq_hi));

  // R2
  dout_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == 'd0) |=> (pad_out == $past(bus_wdata)));

  // R3
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pad_in) && $stable(sync1_q) |=> (sync2_q == $past(pad_in)));
endmodule

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;
  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, pad_in = 0, pad_out, pad_oe;
  logic        irq_lo, irq_hi;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_port u_dut (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
                       .pad_in, .pad_out, .pad_oe, .irq_lo, .irq_hi);

  // reference model built from the requirements
  logic [31:0] m_s1, m_s2, m_s3, m_out, m_dir, m_c0, m_c1, m_msk, m_sts, m_dual;

  function automatic logic [31:0] m_evt();
    logic [31:0] e;
    for (int n = 0; n < 32; n++) begin
      logic [1:0] c;
      c = (n < 16) ? m_c0[2*n +: 2] : m_c1[2*(n-16) +: 2];
      if (m_dual[n]) e[n] = m_s2[n] != m_s3[n];
      else if (c == 0) e[n] = !m_s2[n];
      else if (c == 1) e[n] = m_s2[n];
      else if (c == 2) e[n] = m_s2[n] && !m_s3[n];
      else e[n] = !m_s2[n] && m_s3[n];
    end
    return e;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a[7:2])
      0: return m_out;  1: return m_dir;  2: return m_s2;  3: return m_c0;
      4: return m_c1;   5: return m_msk;  6: return m_sts; 7: return m_dual;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_out <= 0; m_dir <= 0; m_c0 <= 0;
      m_c1 <= 0; m_msk <= 0; m_sts <= 0; m_dual <= 0;
    end else begin
      m_s1 <= pad_in; m_s2 <= m_s1; m_s3 <= m_s2;
      m_sts <= ((bus_wr && bus_addr[7:2] == 6) ? (m_sts & ~bus_wdata) : m_sts) | m_evt();
      if (bus_wr) case (bus_addr[7:2])
        0: m_out <= bus_wdata; 1: m_dir <= bus_wdata; 3: m_c0 <= bus_wdata;
        4: m_c1 <= bus_wdata;  5: m_msk <= bus_wdata; 7: m_dual <= bus_wdata;
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic look(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(0, 8'h00, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!done) $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    #20;
    // R1 reset state
    for (int a = 0; a < 64; a += 4) look("R1 reset", a[7:0], 0);
    chk("R8 reset irq", {30'd0, irq_hi, irq_lo}, 0);
    rst_n = 1;
    // R1 unmapped offsets
    tick(1, 8'h24, 32'hFFFF_FFFF);
    look("R1 unmapped", 8'h24, 0);
    look("R1 unmapped", 8'hFC, 0);
    // R2 output path
    tick(1, 8'h00, 32'hA5A5_0F0F);
    tick(1, 8'h04, 32'hFF00_00FF);
    look("R2 dout readback", 8'h00, 32'hA5A5_0F0F);
    chk("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'hFF00_00FF);
    // R4 all pins rising, then clear
    tick(1, 8'h0C, 32'hAAAA_AAAA);
    tick(1, 8'h10, 32'hAAAA_AAAA);
    tick(1, 8'h18, 32'hFFFF_FFFF);
    look("R6 cleared", 8'h18, 0);
    // R3 latency and R4 rising event on pin 3, R8 irq_lo
    tick(1, 8'h14, 32'h0010_0008);
    @(negedge clk); pad_in = 32'h0000_0008;
    @(posedge clk); #1;
    look("R3 one edge", 8'h08, 0);
    tick(0, 8'h00, 0);
    look("R3 two edges", 8'h08, 32'h8);
    look("R8 status not yet", 8'h18, 0);
    tick(0, 8'h00, 0);
    look("R4 rising pin3", 8'h18, 32'h8);
    chk("R8 irq_lo", {30'd0, irq_hi, irq_lo}, 2'b01);
    // R6 write 0 keeps, write 1 clears
    tick(1, 8'h18, 32'h0);
    look("R6 write0 keeps", 8'h18, 32'h8);
    tick(1, 8'h18, 32'h8);
    look("R6 write1 clears", 8'h18, 0);
    // R4 falling on pin 20 (high word bits 9:8 = 3) lights irq_hi
    tick(1, 8'h10, 32'hAAAA_ABAA);
    @(negedge clk); pad_in = 32'h0010_0008;
    idle(3);
    look("R4 rise ignored on falling pin20", 8'h18, 0);
    @(negedge clk); pad_in = 32'h0000_0008;
    idle(3);
    look("R4 falling pin20", 8'h18, 32'h0010_0000);
    chk("R8 irq_hi", {30'd0, irq_hi, irq_lo}, 2'b10);
    tick(1, 8'h18, 32'hFFFF_FFFF);
    // R5 dual edge on pin 16 overrides its rising code
    tick(1, 8'h1C, 32'h0001_0000);
    @(negedge clk); pad_in = 32'h0001_0008;
    idle(3);
    look("R5 dual rise", 8'h18, 32'h0001_0000);
    tick(1, 8'h18, 32'hFFFF_FFFF);
    @(negedge clk); pad_in = 32'h0000_0008;
    idle(3);
    look("R5 dual fall", 8'h18, 32'h0001_0000);
    chk("R8 irq_hi off for unmasked pin16", {30'd0, irq_hi, irq_lo}, 0);
    tick(1, 8'h18, 32'hFFFF_FFFF);
    // R7 high level on pin 5 (low word bits 11:10 = 1)
    tick(1, 8'h0C, 32'hAAAA_A6AA);
    @(negedge clk); pad_in = 32'h0000_0028;
    idle(3);
    tick(1, 8'h18, 32'h20);
    look("R7 level survives clear", 8'h18, 32'h20);
    @(negedge clk); pad_in = 32'h0000_0008;
    idle(3);
    tick(1, 8'h18, 32'h20);
    look("R7 clears once level gone", 8'h18, 0);
    // R7 low level on pin 31 (high word bits 31:30 = 0) reasserts each cycle
    tick(1, 8'h10, 32'h2AAA_AAAA);
    tick(1, 8'h18, 32'h8000_0000);
    look("R7 low level pin31", 8'h18, 32'h8000_0000);
    look("R1 model agree", 8'h18, m_read(8'h18));
    // random phase against the reference model
    for (int it = 0; it < 4000; it++) begin
      logic [7:0] a;
      logic [31:0] d;
      @(negedge clk);
      pad_in = pad_in ^ ($urandom & $urandom & $urandom);
      a = 8'($urandom_range(0, 9) * 4);
      d = (a == 8'h18) ? ($urandom & $urandom) : $urandom;
      bus_wr = ($urandom_range(0, 3) == 0);
      bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 0;
      a = 8'($urandom_range(0, 9) * 4);
      look(a[7:2] == 6 ? "R6 R7 random status" : a[7:2] == 2 ? "R3 random pads" :
           "R4 R5 random regs", a, m_read(a));
      chk("R8 random irq", {30'd0, irq_hi, irq_lo},
          {30'd0, |(m_sts[31:16] & m_msk[31:16]), |(m_sts[15:0] & m_msk[15:0])});
      chk("R2 random pads out", pad_out ^ pad_oe, m_out ^ m_dir);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule